// File: doc/BRIEF.md
# Dual-Frequency Bridge Gate Sequencer

This block drives the four gates of a transformerless step-up bridge that feeds a diode-capacitor multiplier ladder. One pair of switches, the slow leg, alternates at a period held in an internal timer. That leg sets the sign of the current pushed into the ladder. The other pair, the fast leg, follows an incoming boost PWM signal. The fast leg's roles trade places each time the slow leg changes sides. While the slow leg is on its positive side, PWM high charges the inductor through fast switch A and PWM low delivers energy through fast switch B. On the negative side the mapping is reversed.

The half-period and the overlap length are counted in clock cycles. The block samples both values only at half-period boundaries, so software or a regulator can rewrite them at any time without producing a short or truncated half. Each slow-leg change is make-before-break. For the last few cycles of every half, both slow switches are closed. During that window the fast leg is pinned to the switch that closes the inductor path for the incoming half, so the boost current always has a path.

Top module: `bridge_gate_seq`

## Requirements
- R1: While `rst` is high (synchronous, active high), the outputs are `slowGateP`=1, `slowGateN`=0, `fastGateA`=1, `fastGateB`=0 and `negHalf`=0. At each reset edge, the half-period and overlap settings are loaded from the inputs after clamping.
- R2: Each half lasts exactly H clock cycles, where H is the latched half-period. `negHalf` toggles on the edge that ends the half. Outside the overlap window, `slowGateP` equals the inverse of `negHalf` and `slowGateN` equals `negHalf`.
- R3: In the positive half (`negHalf`=0) outside the overlap, `fastGateA` equals the registered PWM and `fastGateB` equals its inverse.
- R4: In the negative half (`negHalf`=1) outside the overlap, `fastGateB` equals the registered PWM and `fastGateA` equals its inverse.
- R5: The overlap window is the final O cycles of each half, where O is the latched overlap. In that window both slow gates are 1. When O is 0 there is no overlap.
- R6: In the overlap window the PWM input is ignored. The fast switch that charges the inductor for the coming half is held on: `fastGateB` at the end of a positive half and `fastGateA` at the end of a negative half. The other fast gate is off.
- R7: A new half-period or overlap value presented on the inputs has no effect on the current half. It is latched only on the edge that ends the half.
- R8: A half-period input below 2 is treated as 2. An overlap input of H or more is treated as H-1.
- R9: The PWM input is registered once, so fast-gate outputs follow it with one clock cycle of latency.
- R10: At no time are both slow gates off, and exactly one fast gate is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwmIn | input | 1 | Boost modulation signal |
| halfPeriodIn | input | CNT_W | Half-period length in clock cycles |
| overlapIn | input | CNT_W | Overlap length in clock cycles |
| slowGateP | output | 1 | Slow switch for the positive half |
| slowGateN | output | 1 | Slow switch for the negative half |
| fastGateA | output | 1 | Fast switch A (charges in the positive half) |
| fastGateB | output | 1 | Fast switch B (charges in the negative half) |
| negHalf | output | 1 | 1 while the negative-side slow switch owns the half |

## Verification
The hardest situation to reach is a settings change that lands in the middle of a half or inside an overlap window while the PWM input is toggling. Such a change must leave the running half untouched and take effect only after it ends. The stimulus rewrites the half-period and overlap at arbitrary cycles of a running sequence. It also applies an overlap larger than the half-period and a half-period below the minimum, so that the clamps apply at the boundary where the values are latched. It holds the PWM input high across several boundaries, which shows the forced fast gate working against the PWM input.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  // strobes from the timing control to the gate datapath
  typedef struct packed {
    logic negHalf;   // current half belongs to the negative-side slow switch
    logic overlap;   // make-before-break window is active
  } seqStrobe_t;

endpackage

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
  import bseq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] halfPeriodIn,
  input  logic [CNT_W-1:0] overlapIn,
  output seqStrobe_t       strobe
);

  localparam logic [CNT_W-1:0] MIN_HALF = CNT_W'(2);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] halfReq, ovlReq;
  logic [CNT_W-1:0] halfLen, ovlLen, phaseCnt;
  logic             negHalfQ;
  logic             atEnd, inOvl;

  // clamp requested values; applied only when they are latched
  always_comb begin
    halfReq = (halfPeriodIn < MIN_HALF) ? MIN_HALF : halfPeriodIn;
    ovlReq  = (overlapIn >= halfReq) ? (halfReq - ONE) : overlapIn;
  end

  always_comb begin
    atEnd = (phaseCnt == halfLen - ONE);
    inOvl = (phaseCnt >= halfLen - ovlLen);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseCnt <= '0;
      negHalfQ <= 1'b0;
      halfLen  <= halfReq;
      ovlLen   <= ovlReq;
    end else if (atEnd) begin
      phaseCnt <= '0;
      negHalfQ <= ~negHalfQ;
      halfLen  <= halfReq;
      ovlLen   <= ovlReq;
    end else begin
      phaseCnt <= phaseCnt + ONE;
    end
  end

  always_comb begin
    strobe.negHalf = negHalfQ;
    strobe.overlap = inOvl;
  end

  // R8: latched overlap always leaves at least one cycle without overlap
  p_ovl_bounded_r8: assert property (@(posedge clk) disable iff (rst)
    ovlLen < halfLen);
  // R8: latched half-period never below the minimum
  p_half_min_r8: assert property (@(posedge clk) disable iff (rst)
    halfLen >= MIN_HALF);
  // R2: the side flips on the edge that ends a half
  p_flip_r2: assert property (@(posedge clk) disable iff (rst)
    atEnd |=> (negHalfQ != $past(negHalfQ)));
  // R7: side and settings hold inside a half
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !atEnd |=> ($stable(negHalfQ) && $stable(halfLen) && $stable(ovlLen)));
  // R2: phase counter stays inside the half
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    phaseCnt < halfLen);

endmodule

// File: rtl/bseq_gate.sv
module bseq_gate
  import bseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pwmIn,
  input  seqStrobe_t strobe,
  output logic       slowGateP,
  output logic       slowGateN,
  output logic       fastGateA,
  output logic       fastGateB
);

  logic pwmQ;

  // single register stage on the modulation input
  always_ff @(posedge clk) begin
    pwmQ <= pwmIn;
  end

  always_comb begin
    if (rst) begin
      slowGateP = 1'b1;
      slowGateN = 1'b0;
      fastGateA = 1'b1;
      fastGateB = 1'b0;
    end else if (strobe.overlap) begin
      // both slow switches closed; fast leg pinned to the charging
      // switch of the half that is about to start
      slowGateP = 1'b1;
      slowGateN = 1'b1;
      fastGateA = strobe.negHalf;
      fastGateB = ~strobe.negHalf;
    end else begin
      slowGateP = ~strobe.negHalf;
      slowGateN = strobe.negHalf;
      fastGateA = strobe.negHalf ? ~pwmQ : pwmQ;
      fastGateB = strobe.negHalf ? pwmQ : ~pwmQ;
    end
  end

  // R10: fast pair strictly complementary
  p_fast_compl_r10: assert property (@(posedge clk) disable iff (rst)
    fastGateA != fastGateB);
  // R10: slow pair never both open
  p_slow_cover_r10: assert property (@(posedge clk) disable iff (rst)
    slowGateP || slowGateN);
  // R5: overlap closes both slow switches
  p_ovl_both_r5: assert property (@(posedge clk) disable iff (rst)
    strobe.overlap |-> (slowGateP && slowGateN));
  // R6: end of positive half pins fast switch B
  p_force_pos_r6: assert property (@(posedge clk) disable iff (rst)
    (strobe.overlap && !strobe.negHalf) |-> fastGateB);
  // R6: end of negative half pins fast switch A
  p_force_neg_r6: assert property (@(posedge clk) disable iff (rst)
    (strobe.overlap && strobe.negHalf) |-> fastGateA);
  // R3, R9: positive half follows the PWM one cycle late
  p_map_pos_r3: assert property (@(posedge clk) disable iff (rst)
    (!strobe.overlap && !strobe.negHalf) |-> (fastGateA == $past(pwmIn)));

endmodule

// File: rtl/bridge_gate_seq.sv
module bridge_gate_seq
  import bseq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwmIn,
  input  logic [CNT_W-1:0] halfPeriodIn,
  input  logic [CNT_W-1:0] overlapIn,
  output logic             slowGateP,
  output logic             slowGateN,
  output logic             fastGateA,
  output logic             fastGateB,
  output logic             negHalf
);

  seqStrobe_t strobe;

  bseq_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk          (clk),
    .rst          (rst),
    .halfPeriodIn (halfPeriodIn),
    .overlapIn    (overlapIn),
    .strobe       (strobe)
  );

  bseq_gate i_gate (
    .clk       (clk),
    .rst       (rst),
    .pwmIn     (pwmIn),
    .strobe    (strobe),
    .slowGateP (slowGateP),
    .slowGateN (slowGateN),
    .fastGateA (fastGateA),
    .fastGateB (fastGateB)
  );

  assign negHalf = strobe.negHalf;

endmodule

// File: tb/test_bridge_gate_seq.sv
module test_bridge_gate_seq;

  localparam int CNT_W = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic             rst = 1'b1;
  logic             pwm = 1'b0;
  logic [CNT_W-1:0] halfIn = CNT_W'(6);
  logic [CNT_W-1:0] ovlIn  = CNT_W'(2);
  logic slowP, slowN, fastA, fastB, negH;

  bridge_gate_seq #(.CNT_W(CNT_W)) i_bridge_gate_seq (
    .clk          (clk),
    .rst          (rst),
    .pwmIn        (pwm),
    .halfPeriodIn (halfIn),
    .overlapIn    (ovlIn),
    .slowGateP    (slowP),
    .slowGateN    (slowN),
    .fastGateA    (fastA),
    .fastGateB    (fastB),
    .negHalf      (negH)
  );

  int nChecks = 0;
  int nBad    = 0;
  bit done    = 0;

  // reference state built from the requirements
  int mCnt = 0, mH = 2, mO = 0;
  bit mNeg = 0, mPwmQ = 0;

  logic [4:0] expQ[$];
  string      tagQ[$];

  function automatic int clampH(int h);
    return (h < 2) ? 2 : h;
  endfunction

  function automatic int clampO(int o, int h);
    return (o >= h) ? h - 1 : o;
  endfunction

  // driver: applies inputs, advances the reference at the edge, pushes expectation
  task automatic step(bit r, bit p, int h, int o, string tag);
    bit ovl, fa;
    logic [4:0] e;
    rst = r; pwm = p; halfIn = CNT_W'(h); ovlIn = CNT_W'(o);
    @(posedge clk);
    mPwmQ = p;                                    // R9
    if (r) begin
      mNeg = 0; mCnt = 0; mH = clampH(h); mO = clampO(mH == 0 ? 0 : o, mH);
    end else if (mCnt == mH - 1) begin
      mCnt = 0; mNeg = !mNeg; mH = clampH(h); mO = clampO(o, mH);   // R7, R8
    end else begin
      mCnt++;
    end
    ovl = (mCnt >= mH - mO);
    if (r)        e = 5'b10100;                   // R1
    else if (ovl) e = {1'b1, 1'b1, mNeg, !mNeg, mNeg};   // R5, R6
    else begin
      fa = mNeg ? !mPwmQ : mPwmQ;                 // R3, R4
      e  = {!mNeg, mNeg, fa, !fa, mNeg};          // R2
    end
    expQ.push_back(e);
    tagQ.push_back(tag);
    #3;
  endtask

  // monitor: compares away from the active edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      logic [4:0] e, got;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      got = {slowP, slowN, fastA, fastB, negH};
      nChecks++;
      if (got !== e) begin
        nBad++;
        $display("FAIL %s: gates/pol got=%b expected=%b at %0t", t, got, e, $time);
      end
      nChecks++;   // R10
      if (!(got[4] | got[3]) || (got[2] == got[1])) begin
        nBad++;
        $display("FAIL R10: pair coverage got=%b expected slow!=00 and fast one-hot", got);
      end
    end
  end

  initial begin
    #1;
    for (int i = 0; i < 3; i++) step(1, 0, 6, 2, "R1");
    for (int i = 0; i < 30; i++) step(0, ((i * 5) % 7) < 3, 6, 2, "R3 R4 R5 R6 R9");
    // settings rewritten mid-half: take effect only at the boundary
    for (int i = 0; i < 4; i++)  step(0, i[0], 6, 2, "R2");
    for (int i = 0; i < 24; i++) step(0, ((i * 3) % 5) < 2, 9, 3, "R2 R7");
    for (int i = 0; i < 6; i++)  step(0, 1, 4, 1, "R7");
    // clamps
    for (int i = 0; i < 15; i++) step(0, i[1], 5, 20, "R8");
    for (int i = 0; i < 10; i++) step(0, i[0], 1, 7, "R8");
    // no overlap
    for (int i = 0; i < 12; i++) step(0, ((i * 5) % 3) == 0, 4, 0, "R5");
    // reset in the middle of a run, then PWM held high across boundaries
    for (int i = 0; i < 2; i++)  step(1, 1, 5, 2, "R1");
    for (int i = 0; i < 16; i++) step(0, 1, 5, 2, "R4 R6");
    for (int i = 0; i < 10; i++) step(0, 0, 3, 1, "R3 R6");
    done = 1;
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      nChecks++;
      nBad++;
      $display("FAIL watchdog: run hung, got no completion expected completion");
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

endmodule